// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter with a forbidden early-service interval. After each restart, the count first passes through a closed window. Servicing the watchdog in the closed window is treated as a fault. The count then enters an open window, where a service request legally restarts it. If no service arrives before both windows have elapsed, the block raises a watchdog reset. One clock drives the counter, and every enabled cycle advances it by one.

Software programs the block with a single control write. That write carries an enable bit and two 5-bit exponents, one for each window. Each window is a power of two long. Any write that alters the stored control value restarts the count quietly. The reset output is a one-cycle pulse, which a system reset controller consumes. A status output shows which window the count is currently in.

Top module: `win_watchdog`

## Requirements
- R1: After the asynchronous reset (rst_n low), the block is disabled, with wd_reset = 0 and in_open = 0.
- R2: After a restart, the closed window lasts 2^(E_c+1) cycles, where E_c is the closed exponent. in_open goes to 1 in the cycle in which the count reaches that length.
- R3: Without a service request, wd_reset pulses when the count reaches 2^(E_c+1) + 2^(E_o+1) (E_o is the open exponent). The count then restarts in the closed window, so in_open reads 0.
- R4: A service request (kick = 1) sampled while the count is in the closed window gives a wd_reset pulse in the next cycle and restarts the count.
- R5: A service request sampled while the count is in the open window, up to and including the last cycle before timeout, restarts the count without a pulse.
- R6: A control write (cfg_wr = 1) whose {enable, closed exponent, open exponent} differs from the stored value restarts the count without a pulse, whatever the phase.
- R7: A control write that repeats the stored value has no effect on the count, the phase or the timeout.
- R8: While the stored enable is 0, the count is held at zero, kick is ignored and wd_reset stays 0.
- R9: When a changing control write and a kick arrive in the same cycle, the write wins: the count restarts and no pulse is given.
- R10: wd_reset is high for one cycle per fault. It falls in the cycle after a timeout pulse unless another fault occurs.
- R11: in_open is 1 exactly while the count lies at or past the closed-window length and below the total timeout.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_enable | input | 1 | Enable bit of the control write |
| cfg_closed_exp | input | 5 | Closed-window exponent of the control write |
| cfg_open_exp | input | 5 | Open-window exponent of the control write |
| kick | input | 1 | Service (clear) request |
| wd_reset | output | 1 | One-cycle watchdog reset pulse |
| in_open | output | 1 | 1 while the count is in the open window |

## Verification
Every input is sampled at a rising edge, and every result is registered at that same edge. A kick or control write therefore shows its effect on wd_reset and in_open one cycle later. A timeout pulse appears exactly the total window length of edges after the restart edge. The bench drives inputs on falling edges and counts falling edges from the restart. It compares the outputs at the falling edge after the edge that must produce them, never in the middle of an edge. Each vector's expected pulse position and phase boundary come from the exponents alone.

// File: rtl/win_wdt_pkg.sv
package win_wdt_pkg;

  localparam int unsigned WDT_EXP_W = 5;

  typedef enum logic {
    PH_CLOSED = 1'b0,
    PH_OPEN   = 1'b1
  } wdt_phase_e;

  // Length in cycles of a window whose exponent field is e: 2^(e+1).
  function automatic logic [63:0] window_cycles(input logic [5:0] e);
    return 64'd1 << (e + 6'd1);
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int unsigned EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wr_en,
  input  logic [EXP_W-1:0] wr_cexp,
  input  logic [EXP_W-1:0] wr_oexp,
  output logic             en,
  output logic [EXP_W-1:0] cexp,
  output logic [EXP_W-1:0] oexp,
  output logic             chg
);

  localparam int unsigned REG_W = 2 * EXP_W + 1;

  logic [REG_W-1:0] stored_q;
  logic [REG_W-1:0] incoming;

  assign incoming = {wr_en, wr_cexp, wr_oexp};
  assign chg      = wr && (incoming != stored_q);
  assign {en, cexp, oexp} = stored_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
    end else if (chg) begin
      stored_q <= incoming;
    end
  end

endmodule

// File: rtl/wdt_window_cmp.sv
module wdt_window_cmp
  import win_wdt_pkg::*;
#(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned CNT_W = 34
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [EXP_W-1:0] cexp,
  input  logic [EXP_W-1:0] oexp,
  output wdt_phase_e       phase,
  output logic             at_limit
);

  logic [CNT_W-1:0] closed_len;
  logic [CNT_W-1:0] total_len;

  assign closed_len = CNT_W'(window_cycles(6'(cexp)));
  assign total_len  = closed_len + CNT_W'(window_cycles(6'(oexp)));
  assign phase      = (cnt >= closed_len) ? PH_OPEN : PH_CLOSED;
  assign at_limit   = (cnt == total_len - CNT_W'(1));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import win_wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             chg,
  input  logic             kick,
  input  wdt_phase_e       phase,
  input  logic             at_limit,
  output logic [CNT_W-1:0] cnt,
  output logic             bite
);

  logic ev_cfg;
  logic ev_bad_kick;
  logic ev_good_kick;
  logic ev_expire;
  logic restart;

  assign ev_cfg       = chg;
  assign ev_bad_kick  = en && !chg && kick && (phase == PH_CLOSED);
  assign ev_good_kick = en && !chg && kick && (phase == PH_OPEN);
  assign ev_expire    = en && !chg && !kick && at_limit;
  assign restart      = !en || ev_cfg || ev_bad_kick || ev_good_kick || ev_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bite <= 1'b0;
    end else begin
      bite <= ev_bad_kick || ev_expire;
      cnt  <= restart ? '0 : cnt + CNT_W'(1);
    end
  end

  AST_BAD_KICK_BITES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !chg && kick && phase == PH_CLOSED) |=> (bite && cnt == '0)); // R4
  AST_GOOD_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !chg && kick && phase == PH_OPEN) |=> (!bite && cnt == '0)); // R5
  AST_CFG_BEATS_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && kick) |=> (!bite && cnt == '0)); // R9
  AST_CFG_NO_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !bite); // R6
  AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !chg) |=> (!bite && cnt == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !chg && !kick && at_limit) |=> (bite && cnt == '0)); // R3

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import win_wdt_pkg::*;
#(
  parameter int unsigned EXP_W = WDT_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_enable,
  input  logic [EXP_W-1:0] cfg_closed_exp,
  input  logic [EXP_W-1:0] cfg_open_exp,
  input  logic             kick,
  output logic             wd_reset,
  output logic             in_open
);

  // Wide enough for 2^(2^EXP_W) + 2^(2^EXP_W) without wrapping.
  localparam int unsigned CNT_W = (1 << EXP_W) + 2;

  logic             en_q;
  logic [EXP_W-1:0] cexp_q;
  logic [EXP_W-1:0] oexp_q;
  logic             cfg_chg;
  logic [CNT_W-1:0] cnt_q;
  wdt_phase_e       phase;
  logic             at_limit;

  wdt_ctrl_reg #(.EXP_W(EXP_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wr_en   (cfg_enable),
    .wr_cexp (cfg_closed_exp),
    .wr_oexp (cfg_open_exp),
    .en      (en_q),
    .cexp    (cexp_q),
    .oexp    (oexp_q),
    .chg     (cfg_chg)
  );

  wdt_window_cmp #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_cmp (
    .cnt      (cnt_q),
    .cexp     (cexp_q),
    .oexp     (oexp_q),
    .phase    (phase),
    .at_limit (at_limit)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .chg      (cfg_chg),
    .kick     (kick),
    .phase    (phase),
    .at_limit (at_limit),
    .cnt      (cnt_q),
    .bite     (wd_reset)
  );

  assign in_open = (phase == PH_OPEN);

  AST_CLOSED_AFTER_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> !in_open); // R3
  AST_OPEN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_open |-> en_q); // R11

endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int VC [NVEC] = '{0, 1, 1, 1, 2, 2, 0, 3};
  localparam int VP [NVEC] = '{0, 1, 2, 1, 0, 1, 3, 0};
  localparam int VQ [NVEC] = '{-1, 3, -1, 4, 1, 8, 17, -1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_enable = 1'b0;
  logic [4:0] cfg_closed_exp = '0;
  logic [4:0] cfg_open_exp = '0;
  logic       kick = 1'b0;
  logic       wd_reset;
  logic       in_open;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  win_watchdog uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_enable     (cfg_enable),
    .cfg_closed_exp (cfg_closed_exp),
    .cfg_open_exp   (cfg_open_exp),
    .kick           (kick),
    .wd_reset       (wd_reset),
    .in_open        (in_open)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0b expected=%0b at t=%0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic cfg(input logic e, input int c, input int p);
    cfg_wr = 1'b1;
    cfg_enable = e;
    cfg_closed_exp = 5'(c);
    cfg_open_exp = 5'(p);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cl;
    int tl;
    @(negedge clk);
    @(negedge clk);
    chk("R1 wd_reset in reset", wd_reset, 1'b0);
    chk("R1 in_open in reset", in_open, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wd_reset after reset", wd_reset, 1'b0);

    // R8: disabled after reset, kicks ignored
    for (int i = 0; i < 20; i++) begin
      kick = (i % 3) != 0;
      @(negedge clk);
      chk("R8 no pulse while disabled", wd_reset, 1'b0);
      chk("R8 closed while disabled", in_open, 1'b0);
    end
    kick = 1'b0;

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      cl = 1 << (VC[v] + 1);
      tl = cl + (1 << (VP[v] + 1));
      cfg(1'b1, VC[v], VP[v]);
      if (VQ[v] < 0) begin
        for (int k = 1; k <= tl + 1; k++) begin
          @(negedge clk);
          if (k <= tl) begin
            chk("R2/R11 phase", in_open, (k >= cl) && (k < tl));
            chk("R3 timeout pulse", wd_reset, k == tl);
          end else begin
            chk("R10 pulse ends", wd_reset, 1'b0);
            chk("R3 restart closed", in_open, 1'b0);
          end
        end
      end else begin
        for (int k = 1; k <= VQ[v]; k++) begin
          @(negedge clk);
          chk("R11 phase before kick", in_open, k >= cl);
        end
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        if (VQ[v] < cl) chk("R4 closed kick pulses", wd_reset, 1'b1);
        else            chk("R5 open kick quiet", wd_reset, 1'b0);
        chk("R4/R5 kick restarts closed", in_open, 1'b0);
        @(negedge clk);
        chk("R10 single cycle", wd_reset, 1'b0);
      end
    end

    // R6: changing write late in open window restarts quietly
    cfg(1'b1, 1, 1);            // closed 4, total 8
    step(6);
    chk("R6 open before write", in_open, 1'b1);
    cfg(1'b1, 1, 2);            // closed 4, total 12
    chk("R6 no pulse on write", wd_reset, 1'b0);
    chk("R6 restart closed", in_open, 1'b0);
    step(3);
    chk("R6 still closed at 3", in_open, 1'b0);
    step(1);
    chk("R6 open at 4", in_open, 1'b1);
    step(7);
    chk("R6 no pulse at 11", wd_reset, 1'b0);
    step(1);
    chk("R6 timeout at 12", wd_reset, 1'b1);

    // R7: identical write has no effect
    cfg(1'b1, 1, 1);            // total 8
    step(6);
    cfg(1'b1, 1, 1);            // same value, count reaches 7
    chk("R7 still open", in_open, 1'b1);
    chk("R7 no pulse at 7", wd_reset, 1'b0);
    step(1);
    chk("R7 timeout unchanged", wd_reset, 1'b1);

    // R9: changing write with kick in closed window
    cfg(1'b1, 1, 2);
    step(1);
    kick = 1'b1;
    cfg(1'b1, 1, 1);
    kick = 1'b0;
    chk("R9 write beats kick", wd_reset, 1'b0);
    step(3);
    chk("R9 closed at 3", in_open, 1'b0);
    step(1);
    chk("R9 restart confirmed at 4", in_open, 1'b1);

    // R8: disable while running in open window
    cfg(1'b0, 1, 1);
    chk("R8 disable write quiet", wd_reset, 1'b0);
    for (int i = 0; i < 30; i++) begin
      kick = i[0];
      @(negedge clk);
      chk("R8 disabled no pulse", wd_reset, 1'b0);
      chk("R8 disabled held", in_open, 1'b0);
    end
    kick = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule